// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer that takes 18-bit words on a write clock and hands them out on an independent read clock. The two sides can run at the same time. A write enable and a read enable qualify each access. Writes into a full buffer and reads from an empty one are dropped. The depth is 512 words by default and can be set to any power of two, such as 1024 or 2048.

Each side keeps its own status. The write side reports full, half full and almost full. The read side reports empty and almost empty. Both almost thresholds load through a small register port in the write domain. The read side can record a mark position and later rewind its read pointer to that mark, so that a span of data can be read again. Parity can be generated on write, which replaces the top bit with the XOR of the lower bits. Parity can also be checked on read, which flags a word whose bits XOR to one. An output enable gates the read data and its valid strobe.

Top module: `dcfifo_flags`

## Requirements
- R1: After reset, empty and almost_empty are 1, and full, half_full, almost_full and dout_vld are 0.
- R2: Words leave in the order they were written. An accepted read puts the word on dout with dout_vld high in the next read-clock cycle.
- R3: A write while full is ignored. Nothing is stored and the write pointer does not move.
- R4: A read while empty is ignored. dout_vld stays low and no word is consumed.
- R5: full is 1 exactly when the write side sees DEPTH words stored.
- R6: half_full is 1 when the write-side occupancy is at least DEPTH/2.
- R7: almost_full is 1 when the write-side occupancy is at least DEPTH minus the full threshold. A thr_we pulse loads thr_val into the full threshold when thr_sel=1, and into the empty threshold when thr_sel=0.
- R8: almost_empty is 1 when the read-side occupancy is at most the empty threshold. empty implies almost_empty.
- R9: A mark pulse records the current read position, and reset sets the mark to the first word. An rt pulse moves the read pointer back to the mark, so the words from the mark onward are read again.
- R10: With par_gen=1, bit 17 of the stored word is the XOR of bits 16:0. With par_gen=0 the word is stored unchanged.
- R11: par_err comes with dout_vld. It is 1 when par_chk was 1 at the read and the XOR of all 18 bits of the word is 1.
- R12: With oe=0, dout is all zeros and dout_vld is 0, but an accepted read still consumes its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wrst | input | 1 | Synchronous active-high reset, write side |
| wr_en | input | 1 | Write request |
| wdata | input | 18 | Write word |
| par_gen | input | 1 | Replace bit 17 with generated parity |
| thr_we | input | 1 | Load a threshold |
| thr_sel | input | 1 | 0 selects the empty threshold, 1 selects the full threshold |
| thr_val | input | 10 | Threshold value |
| full | output | 1 | Buffer full |
| half_full | output | 1 | Occupancy at least DEPTH/2 |
| almost_full | output | 1 | Occupancy at least DEPTH minus the full threshold |
| rclk | input | 1 | Read clock |
| rrst | input | 1 | Synchronous active-high reset, read side |
| rd_en | input | 1 | Read request |
| rt | input | 1 | Rewind the read pointer to the mark |
| mark | input | 1 | Record the current read position |
| oe | input | 1 | Output enable |
| par_chk | input | 1 | Check parity on this read |
| dout | output | 18 | Read word, zero when oe=0 |
| dout_vld | output | 1 | dout carries a freshly read word |
| par_err | output | 1 | Parity mismatch on the word on dout |
| empty | output | 1 | Buffer empty |
| almost_empty | output | 1 | Occupancy at most the empty threshold |

## Verification
Some properties are checked on every clock edge: a dropped write while full leaves the write pointer unchanged, and a dropped read while empty leaves the read pointer unchanged. The flags must also stay consistent with each other: full implies half full and almost full, and empty implies almost empty. Word order, the exact occupancy at which each flag switches, the rewind to a mark, parity generation and checking, and output gating all depend on the stimulus over many cycles and on both clocks. The directed scenarios in the bench check these.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;
  typedef enum logic {
    THR_SEL_EMPTY = 1'b0,
    THR_SEL_FULL  = 1'b1
  } thr_sel_e;
endpackage

// File: rtl/cfifo_sync.sv
module cfifo_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= '0;
        else     stage[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= '0;
        else     stage[s] <= stage[s-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/cfifo_gray2bin.sv
module cfifo_gray2bin #(
  parameter int W = 4
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  always_comb begin
    bin[W-1] = gray[W-1];
    for (int i = W - 2; i >= 0; i--) bin[i] = bin[i+1] ^ gray[i];
  end
endmodule

// File: rtl/cfifo_ram.sv
module cfifo_ram #(
  parameter int DW = 18,
  parameter int AW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdat,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdat
);
  localparam int WORDS = 2 ** AW;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdat;
  end

  always_ff @(posedge rclk) begin
    if (re) rdat <= mem[raddr];
  end
endmodule

// File: rtl/cfifo_wr_ctrl.sv
module cfifo_wr_ctrl
  import cfifo_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int AE_DEF = 8,
  parameter int AF_DEF = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              wclk,
  input  logic              wrst,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  rgray_s,
  input  logic              thr_we,
  input  logic              thr_sel,
  input  logic [PTR_W-1:0]  thr_val,
  output logic              push,
  output logic [ADDR_W-1:0] waddr,
  output logic [PTR_W-1:0]  wgray,
  output logic              full,
  output logic              half_full,
  output logic              almost_full,
  output logic [PTR_W-1:0]  ae_thr
);
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] HALF_P  = PTR_W'(DEPTH / 2);

  logic [PTR_W-1:0] wbin, wbin_n, rbin_s, cnt_n, af_thr;

  cfifo_gray2bin #(.W(PTR_W)) u_rg2b (.gray(rgray_s), .bin(rbin_s));

  assign push   = wr_en && !full;
  assign wbin_n = wbin + PTR_W'(push);
  assign cnt_n  = wbin_n - rbin_s;
  assign waddr  = wbin[ADDR_W-1:0];

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin        <= '0;
      wgray       <= '0;
      full        <= 1'b0;
      half_full   <= 1'b0;
      almost_full <= 1'b0;
    end else begin
      wbin        <= wbin_n;
      wgray       <= wbin_n ^ (wbin_n >> 1);
      full        <= (cnt_n == DEPTH_P);
      half_full   <= (cnt_n >= HALF_P);
      almost_full <= (cnt_n >= (DEPTH_P - af_thr));
    end
  end

  always_ff @(posedge wclk) begin
    if (wrst) begin
      ae_thr <= PTR_W'(AE_DEF);
      af_thr <= PTR_W'(AF_DEF);
    end else if (thr_we) begin
      unique case (thr_sel_e'(thr_sel))
        THR_SEL_EMPTY: ae_thr <= thr_val;
        THR_SEL_FULL:  af_thr <= thr_val;
      endcase
    end
  end

  // R3: a write refused while full must leave the write pointer in place
  a_r3_full_hold : assert property (@(posedge wclk) disable iff (wrst)
    (full && wr_en) |=> (wbin == $past(wbin)));

  // R6: full occupancy is always at least half occupancy
  a_r6_full_half : assert property (@(posedge wclk) disable iff (wrst)
    full |-> half_full);

  // R7: full occupancy is always at or above the almost-full level
  a_r7_full_afull : assert property (@(posedge wclk) disable iff (wrst)
    full |-> almost_full);
endmodule

// File: rtl/cfifo_rd_ctrl.sv
module cfifo_rd_ctrl #(
  parameter int DEPTH = 512,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              rclk,
  input  logic              rrst,
  input  logic              rd_en,
  input  logic              rt,
  input  logic              mark,
  input  logic              par_chk,
  input  logic [PTR_W-1:0]  wgray_s,
  input  logic [PTR_W-1:0]  ae_thr_s,
  output logic              pop,
  output logic [ADDR_W-1:0] raddr,
  output logic [PTR_W-1:0]  rgray,
  output logic              empty,
  output logic              almost_empty,
  output logic              rvalid,
  output logic              chk_q
);
  logic [PTR_W-1:0] rbin, rbin_n, wbin_s, mark_q, cnt_n;

  cfifo_gray2bin #(.W(PTR_W)) u_wg2b (.gray(wgray_s), .bin(wbin_s));

  assign pop    = rd_en && !empty && !rt;
  assign rbin_n = rt ? mark_q : rbin + PTR_W'(pop);
  assign cnt_n  = wbin_s - rbin_n;
  assign raddr  = rbin[ADDR_W-1:0];

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin         <= '0;
      rgray        <= '0;
      mark_q       <= '0;
      empty        <= 1'b1;
      almost_empty <= 1'b1;
      rvalid       <= 1'b0;
      chk_q        <= 1'b0;
    end else begin
      rbin         <= rbin_n;
      rgray        <= rbin_n ^ (rbin_n >> 1);
      empty        <= (cnt_n == '0);
      almost_empty <= (cnt_n <= ae_thr_s);
      rvalid       <= pop;
      if (mark) mark_q <= rbin;
      if (pop)  chk_q  <= par_chk;
    end
  end

  // R4: a read refused while empty must leave the read pointer in place
  a_r4_empty_hold : assert property (@(posedge rclk) disable iff (rrst)
    (empty && rd_en && !rt) |=> (rbin == $past(rbin)));

  // R8: an empty buffer is always below the almost-empty level
  a_r8_empty_aempty : assert property (@(posedge rclk) disable iff (rrst)
    empty |-> almost_empty);
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 512,
  parameter int AE_DEF = 8,
  parameter int AF_DEF = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              wclk,
  input  logic              wrst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              par_gen,
  input  logic              thr_we,
  input  logic              thr_sel,
  input  logic [PTR_W-1:0]  thr_val,
  output logic              full,
  output logic              half_full,
  output logic              almost_full,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              rd_en,
  input  logic              rt,
  input  logic              mark,
  input  logic              oe,
  input  logic              par_chk,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld,
  output logic              par_err,
  output logic              empty,
  output logic              almost_empty
);
  logic              push, pop, rvalid, chk_q;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PTR_W-1:0]  wgray, rgray, wgray_s, rgray_s, ae_thr, ae_thr_s;
  logic [DATA_W-1:0] wword, rword;

  assign wword = par_gen ? {^wdata[DATA_W-2:0], wdata[DATA_W-2:0]} : wdata;

  cfifo_wr_ctrl #(.DEPTH(DEPTH), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_wr (
    .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .rgray_s(rgray_s),
    .thr_we(thr_we), .thr_sel(thr_sel), .thr_val(thr_val),
    .push(push), .waddr(waddr), .wgray(wgray), .full(full),
    .half_full(half_full), .almost_full(almost_full), .ae_thr(ae_thr)
  );

  cfifo_sync #(.W(PTR_W)) u_sync_r2w (.clk(wclk), .rst(wrst), .d(rgray), .q(rgray_s));
  cfifo_sync #(.W(PTR_W)) u_sync_w2r (.clk(rclk), .rst(rrst), .d(wgray), .q(wgray_s));
  cfifo_sync #(.W(PTR_W)) u_sync_thr (.clk(rclk), .rst(rrst), .d(ae_thr), .q(ae_thr_s));

  cfifo_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .rclk(rclk), .rrst(rrst), .rd_en(rd_en), .rt(rt), .mark(mark),
    .par_chk(par_chk), .wgray_s(wgray_s), .ae_thr_s(ae_thr_s),
    .pop(pop), .raddr(raddr), .rgray(rgray), .empty(empty),
    .almost_empty(almost_empty), .rvalid(rvalid), .chk_q(chk_q)
  );

  cfifo_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk(wclk), .we(push), .waddr(waddr), .wdat(wword),
    .rclk(rclk), .re(pop), .raddr(raddr), .rdat(rword)
  );

  assign dout     = oe ? rword : '0;
  assign dout_vld = oe && rvalid;
  assign par_err  = oe && rvalid && chk_q && (^rword);
endmodule

// File: tb/test_dcfifo_flags.sv
module test_dcfifo_flags;
  localparam int DEPTH = 512;
  localparam int PW    = 10;

  logic wclk = 0, rclk = 0;
  logic wrst = 1, rrst = 1;
  logic wr_en = 0, par_gen = 0, thr_we = 0, thr_sel = 0;
  logic [17:0] wdata = '0;
  logic [PW-1:0] thr_val = '0;
  logic rd_en = 0, rt = 0, mark = 0, oe = 1, par_chk = 0;
  logic full, half_full, almost_full, dout_vld, par_err, empty, almost_empty;
  logic [17:0] dout;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [17:0] next_w = 0, next_r = 0;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  dcfifo_flags #(.DEPTH(DEPTH)) i_dcfifo_flags (
    .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .wdata(wdata), .par_gen(par_gen),
    .thr_we(thr_we), .thr_sel(thr_sel), .thr_val(thr_val),
    .full(full), .half_full(half_full), .almost_full(almost_full),
    .rclk(rclk), .rrst(rrst), .rd_en(rd_en), .rt(rt), .mark(mark), .oe(oe),
    .par_chk(par_chk), .dout(dout), .dout_vld(dout_vld), .par_err(par_err),
    .empty(empty), .almost_empty(almost_empty)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge wclk);
    repeat (4) @(negedge rclk);
    repeat (2) @(negedge wclk);
  endtask

  task automatic wr_one(logic [17:0] d);
    @(negedge wclk); wr_en = 1; wdata = d;
    @(negedge wclk); wr_en = 0;
  endtask

  task automatic wr_n(int n);
    @(negedge wclk);
    wr_en = 1;
    for (int i = 0; i < n; i++) begin
      wdata = next_w; next_w = next_w + 1;
      @(negedge wclk);
    end
    wr_en = 0;
  endtask

  task automatic rd_one(output logic [17:0] d, output logic v, output logic pe);
    @(negedge rclk); rd_en = 1;
    @(negedge rclk); rd_en = 0;
    d = dout; v = dout_vld; pe = par_err;
  endtask

  task automatic rd_n(int n, string req);
    logic [17:0] d; logic v, pe;
    for (int i = 0; i < n; i++) begin
      rd_one(d, v, pe);
      chk({req, " vld"}, 32'(v), 1);
      chk({req, " data"}, 32'(d), 32'(next_r));
      next_r = next_r + 1;
    end
  endtask

  task automatic pulse_r(ref logic s);
    @(negedge rclk); s = 1;
    @(negedge rclk); s = 0;
  endtask

  task automatic load_thr(logic sel, logic [PW-1:0] v);
    @(negedge wclk); thr_we = 1; thr_sel = sel; thr_val = v;
    @(negedge wclk); thr_we = 0;
  endtask

  task automatic t_reset();
    chk("R1 empty", 32'(empty), 1);
    chk("R1 almost_empty", 32'(almost_empty), 1);
    chk("R1 full", 32'(full), 0);
    chk("R1 half_full", 32'(half_full), 0);
    chk("R1 almost_full", 32'(almost_full), 0);
    chk("R1 dout_vld", 32'(dout_vld), 0);
  endtask

  task automatic t_order();
    wr_n(5); settle();
    chk("R2 not empty", 32'(empty), 0);
    rd_n(5, "R2");
    settle();
    chk("R2 empty after drain", 32'(empty), 1);
  endtask

  task automatic t_fill();
    logic [17:0] d; logic v, pe;
    wr_n(DEPTH); settle();
    chk("R5 full", 32'(full), 1);
    chk("R6 half at full", 32'(half_full), 1);
    chk("R7 afull at full", 32'(almost_full), 1);
    for (int i = 0; i < 3; i++) wr_one(18'h3FFFF);  // R3 dropped writes
    settle();
    rd_n(DEPTH, "R3");
    settle();
    chk("R5 full cleared", 32'(full), 0);
    chk("R4 empty", 32'(empty), 1);
    rd_one(d, v, pe);
    chk("R4 read while empty vld", 32'(v), 0);
    wr_one(18'h155AA); settle();
    rd_one(d, v, pe);
    chk("R4 nothing consumed data", 32'(d), 32'h155AA);
    settle();
  endtask

  task automatic t_half();
    wr_n(DEPTH / 2 - 1); settle();
    chk("R6 half below", 32'(half_full), 0);
    wr_n(1); settle();
    chk("R6 half at DEPTH/2", 32'(half_full), 1);
    rd_n(DEPTH / 2, "R6 drain");
    settle();
  endtask

  task automatic t_thresholds();
    load_thr(1'b1, PW'(4));
    load_thr(1'b0, PW'(3));
    settle();
    wr_n(3); settle();
    chk("R8 aempty at threshold", 32'(almost_empty), 1);
    wr_n(1); settle();
    chk("R8 aempty above threshold", 32'(almost_empty), 0);
    wr_n(DEPTH - 9); settle();
    chk("R7 afull below", 32'(almost_full), 0);
    wr_n(1); settle();
    chk("R7 afull at DEPTH-4", 32'(almost_full), 1);
    chk("R5 not full", 32'(full), 0);
    rd_n(DEPTH - 4, "R7 drain");
    settle();
  endtask

  task automatic t_retransmit();
    logic [17:0] m;
    pulse_r(mark); m = next_r;
    wr_n(3); settle();
    rd_n(3, "R9 first pass");
    settle();
    chk("R9 empty before rt", 32'(empty), 1);
    pulse_r(rt); settle();
    chk("R9 not empty after rt", 32'(empty), 0);
    next_r = m;
    rd_n(3, "R9 replay");
    settle();
    chk("R9 empty after replay", 32'(empty), 1);
    wr_n(2); settle();
    rd_n(1, "R9 before mid mark");
    pulse_r(mark); m = next_r;
    rd_n(1, "R9 after mid mark");
    pulse_r(rt); settle();
    next_r = m;
    rd_n(1, "R9 mid replay");
    settle();
  endtask

  task automatic t_parity();
    logic [17:0] d; logic v, pe;
    par_gen = 1; par_chk = 1;
    wr_one(18'h00001); settle();
    rd_one(d, v, pe);
    chk("R10 generated bit", 32'(d), 32'h20001);
    chk("R11 good parity", 32'(pe), 0);
    par_gen = 0;
    wr_one(18'h00001); settle();
    rd_one(d, v, pe);
    chk("R10 stored unchanged", 32'(d), 32'h00001);
    chk("R11 bad parity flagged", 32'(pe), 1);
    par_chk = 0;
    wr_one(18'h00001); settle();
    rd_one(d, v, pe);
    chk("R11 check disabled", 32'(pe), 0);
    settle();
  endtask

  task automatic t_oe();
    logic [17:0] d; logic v, pe;
    wr_one(18'h0ABCD); wr_one(18'h01234); settle();
    oe = 0;
    rd_one(d, v, pe);
    chk("R12 dout zero", 32'(d), 0);
    chk("R12 vld low", 32'(v), 0);
    oe = 1;
    rd_one(d, v, pe);
    chk("R12 read consumed", 32'(d), 32'h01234);
    chk("R12 vld with oe", 32'(v), 1);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge rclk);
    @(negedge wclk); wrst = 0;
    @(negedge rclk); rrst = 0;
    settle();
    t_reset();
    t_order();
    t_fill();
    t_half();
    t_thresholds();
    t_retransmit();
    t_parity();
    t_oe();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule